// File: doc/BRIEF.md
# Serial Control Word Framer for a Line Front End

This block sits on the host side of a symbol-rate link to a line front end. Once per symbol period it sends that front end one control word. It runs from a continuous oversampling clock at 48 times the symbol rate. A symbol strobe, level-toggling at the symbol rate, marks the start of each period. The framer first resynchronises the strobe. It then captures the control inputs into a shadow word on the strobe's rising edge, and shifts that word out MSB first over the first 16 oversampling periods. For the rest of the period it holds the data line low.

The word carries a transmit enable, a symbol code, a receive gain code, a loopback flag and a transmit boost flag. An all-zero reserved byte sits at the top of the word. While the transmit enable is 0, the symbol code is replaced by the zero-symbol code, so the front end never emits a live symbol from a disabled transmitter. The serial output changes on falling clock edges, so it is settled when the far end samples on rising edges.

Top module: `ctlword_framer`

## Requirements
- R1: While reset is asserted and after its release, `ser_out` and `word_active` are 0 until a rising edge of `baud_strobe` has been seen.
- R2: A rising edge of `baud_strobe` that is first sampled high at rising clock edge n makes `word_active` rise on the falling edge after rising edge n+SYNC_STAGES (n+2 by default). The first word bit appears at the same time.
- R3: `word_active` stays high for exactly 16 clock periods per frame. It then stays low for the rest of the 48-period symbol period, and until the next accepted strobe edge.
- R4: During the 16 active periods, `ser_out` carries word bits 15 down to 0, one bit per clock period.
- R5: Word layout: bit 0 transmit enable, bits 2:1 symbol code (bit 2 its MSB), bits 5:3 receive gain (bit 5 its MSB), bit 6 loopback, bit 7 boost, bits 15:8 always 0.
- R6: When the captured transmit enable is 0, bits 2:1 of the word equal the zero-symbol code 2'b00, whatever `sym_code` holds.
- R7: The control inputs are captured on the rising clock edge at which the frame starts. Changes after that edge do not alter the word being sent.
- R8: `ser_out` is 0 whenever `word_active` is 0.
- R9: With OUT_ON_FALL set (the default), `ser_out` and `word_active` change only on falling clock edges and are stable across rising edges.
- R10: Only rising strobe edges start frames. A strobe held high starts exactly one frame, and a rising edge that arrives during the 16 active periods is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| os_clk | input | 1 | Oversampling clock, 48 periods per symbol |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_strobe | input | 1 | Symbol-rate strobe; a rising edge starts a frame |
| tx_on | input | 1 | Transmit enable field |
| sym_code | input | SYM_W | Symbol code field |
| rx_gain_code | input | GAIN_W | Receive gain field |
| loop_on | input | 1 | Loopback field |
| boost_on | input | 1 | Transmit boost field |
| ser_out | output | 1 | Serial word data, MSB first |
| word_active | output | 1 | High during the 16 data periods |

## Verification
The checker samples every rising edge and checks the frame shape continuously. Each burst of `word_active` must last exactly 16 periods, and the line must be low outside bursts. The reserved byte must read as zeros, and a transmitted enable bit of 0 must follow a zero-symbol field. Only the bench's scenarios can show the rest: that each bit equals the value computed from the inputs, the strobe-to-word latency, the immunity of a word in flight to input changes and to early strobe edges, and the falling-edge launch. The bench covers these by sweeping every combination of the control fields.

// File: rtl/ctlfr_pkg.sv
package ctlfr_pkg;

   // Position of the frame sequencer within one symbol period
   typedef enum logic [1:0] {
      PH_WAIT = 2'd0,   // no strobe edge seen since reset
      PH_DATA = 2'd1,   // shifting word bits
      PH_GAP  = 2'd2    // idle remainder of the period
   } frame_phase_e;

   // Number of fixed single-bit fields in the word (enable, loopback, boost)
   localparam int FLAG_BITS = 3;

endpackage

// File: rtl/ctlfr_edge.sv
module ctlfr_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   output logic rise_pulse
);

   generate
      if (STAGES == 0) begin : g_direct
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= strobe_in;
         end
         assign rise_pulse = strobe_in & ~prev_q;
      end else begin : g_sync
         logic [STAGES:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], strobe_in};
         end
         assign rise_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];
      end
   endgenerate

endmodule

// File: rtl/ctlfr_assemble.sv
module ctlfr_assemble #(
   parameter int              SYM_W    = 2,
   parameter int              GAIN_W   = 3,
   parameter int              RSV_W    = 8,
   parameter logic [SYM_W-1:0] ZERO_SYM = '0,
   localparam int             WB       = RSV_W + GAIN_W + SYM_W + ctlfr_pkg::FLAG_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              tx_en,
   input  logic [SYM_W-1:0]  sym,
   input  logic [GAIN_W-1:0] gain,
   input  logic              loop_en,
   input  logic              boost_en,
   output logic [WB-1:0]     word_q
);

   logic [SYM_W-1:0] sym_eff;
   logic [WB-1:0]    word_next;

   always_comb begin
      // a disabled transmitter always carries the zero symbol
      sym_eff   = tx_en ? sym : ZERO_SYM;
      word_next = {{RSV_W{1'b0}}, boost_en, loop_en, gain, sym_eff, tx_en};
   end

   // shadow copy held for the whole frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= word_next;
   end

endmodule

// File: rtl/ctlfr_seq.sv
module ctlfr_seq #(
   parameter  int PERIOD = 48,
   parameter  int WB     = 16,
   localparam int CNT_W  = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [CNT_W-1:0] cnt_q,
   output logic             data_phase
);
   import ctlfr_pkg::*;

   localparam logic [CNT_W-1:0] LAST     = CNT_W'(PERIOD - 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WB - 1);

   frame_phase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= LAST;
         phase_q <= PH_WAIT;
      end else if (start) begin
         cnt_q   <= '0;
         phase_q <= PH_DATA;
      end else if (phase_q != PH_WAIT && cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST_BIT) phase_q <= PH_GAP;
      end
   end

   assign data_phase = (phase_q == PH_DATA);

endmodule

// File: rtl/ctlfr_txreg.sv
module ctlfr_txreg #(
   parameter  int WB          = 16,
   parameter  int CNT_W       = 6,
   parameter  bit OUT_ON_FALL = 1'b1,
   localparam int IDX_W       = $clog2(WB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_phase,
   input  logic [CNT_W-1:0] cnt,
   input  logic [WB-1:0]    word,
   output logic             ser_out,
   output logic             word_active
);

   logic [IDX_W-1:0] sel;
   logic             bit_next;

   always_comb begin
      sel      = IDX_W'(WB - 1) - cnt[IDX_W-1:0];
      bit_next = data_phase & word[sel];
   end

   generate
      if (OUT_ON_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ser_out     <= 1'b0;
               word_active <= 1'b0;
            end else begin
               ser_out     <= bit_next;
               word_active <= data_phase;
            end
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ser_out     <= 1'b0;
               word_active <= 1'b0;
            end else begin
               ser_out     <= bit_next;
               word_active <= data_phase;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ctlword_framer.sv
module ctlword_framer #(
   parameter int               SYM_W       = 2,
   parameter int               GAIN_W      = 3,
   parameter int               RSV_W       = 8,
   parameter int               PERIOD      = 48,
   parameter int               SYNC_STAGES = 2,
   parameter bit               OUT_ON_FALL = 1'b1,
   parameter logic [SYM_W-1:0] ZERO_SYM    = '0
) (
   input  logic              os_clk,
   input  logic              rst_n,
   input  logic              baud_strobe,
   input  logic              tx_on,
   input  logic [SYM_W-1:0]  sym_code,
   input  logic [GAIN_W-1:0] rx_gain_code,
   input  logic              loop_on,
   input  logic              boost_on,
   output logic              ser_out,
   output logic              word_active
);

   localparam int WORD_BITS = RSV_W + GAIN_W + SYM_W + ctlfr_pkg::FLAG_BITS;
   localparam int CNT_W     = $clog2(PERIOD);

   generate
      if (PERIOD <= WORD_BITS) begin : g_bad_period
         $error("PERIOD must exceed the word length");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (SYM_W < 1 || GAIN_W < 1 || RSV_W < 0) begin : g_bad_field
         $error("field widths out of range");
      end
   endgenerate

   logic             rise_raw;
   logic             start_ok;
   logic             data_phase;
   logic [CNT_W-1:0] cnt;
   logic [WORD_BITS-1:0] word_q;

   ctlfr_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk        (os_clk),
      .rst_n      (rst_n),
      .strobe_in  (baud_strobe),
      .rise_pulse (rise_raw)
   );

   // edges during the data periods are not acted on
   assign start_ok = rise_raw & ~data_phase;

   ctlfr_assemble #(
      .SYM_W    (SYM_W),
      .GAIN_W   (GAIN_W),
      .RSV_W    (RSV_W),
      .ZERO_SYM (ZERO_SYM)
   ) u_asm (
      .clk      (os_clk),
      .rst_n    (rst_n),
      .load     (start_ok),
      .tx_en    (tx_on),
      .sym      (sym_code),
      .gain     (rx_gain_code),
      .loop_en  (loop_on),
      .boost_en (boost_on),
      .word_q   (word_q)
   );

   ctlfr_seq #(.PERIOD(PERIOD), .WB(WORD_BITS)) u_seq (
      .clk        (os_clk),
      .rst_n      (rst_n),
      .start      (start_ok),
      .cnt_q      (cnt),
      .data_phase (data_phase)
   );

   ctlfr_txreg #(
      .WB          (WORD_BITS),
      .CNT_W       (CNT_W),
      .OUT_ON_FALL (OUT_ON_FALL)
   ) u_tx (
      .clk         (os_clk),
      .rst_n       (rst_n),
      .data_phase  (data_phase),
      .cnt         (cnt),
      .word        (word_q),
      .ser_out     (ser_out),
      .word_active (word_active)
   );

endmodule

// File: rtl/ctlfr_chk.sv
module ctlfr_chk #(
   parameter int               WB       = 16,
   parameter int               RSV_W    = 8,
   parameter int               SYM_W    = 2,
   parameter logic [SYM_W-1:0] ZERO_SYM = '0
) (
   input logic clk,
   input logic rst_n,
   input logic ser_out,
   input logic word_active
);

   localparam int RL_W = $clog2(WB + 1) + 1;

   logic [RL_W-1:0]  run_len;
   logic [SYM_W-1:0] sym_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_len <= '0;
      else if (word_active) begin
         if (run_len != '1) run_len <= run_len + 1'b1;
      end else              run_len <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sym_seen <= '0;
      else if (word_active && run_len >= RL_W'(WB - 1 - SYM_W) && run_len < RL_W'(WB - 1))
         sym_seen <= (sym_seen << 1) | SYM_W'(ser_out);
   end

   // R8
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_active |-> !ser_out);

   // R3
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(word_active) |-> run_len == RL_W'(WB));

   // R3
   burst_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_active |-> run_len < RL_W'(WB));

   // R5
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_active && run_len < RL_W'(RSV_W)) |-> !ser_out);

   // R6
   sym_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_active && run_len == RL_W'(WB - 1) && !ser_out) |-> sym_seen == ZERO_SYM);

endmodule

bind ctlword_framer ctlfr_chk #(
   .WB       (WORD_BITS),
   .RSV_W    (RSV_W),
   .SYM_W    (SYM_W),
   .ZERO_SYM (ZERO_SYM)
) u_chk (
   .clk         (os_clk),
   .rst_n       (rst_n),
   .ser_out     (ser_out),
   .word_active (word_active)
);

// File: tb/sim_ctlword_framer.sv
module sim_ctlword_framer;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int SYNC = 2;
   localparam int WB   = 16;
   localparam int PER  = 48;
   localparam int LAT  = SYNC + 2;   // sample index of the first active period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud = 1'b0;
   logic       tx_on = 1'b0, loop_on = 1'b0, boost_on = 1'b0;
   logic [1:0] sym = '0;
   logic [2:0] gain = '0;
   logic       ser_out, word_active;
   logic       pre_act, pre_ser;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ctlword_framer u0 (
      .os_clk       (clk),
      .rst_n        (rst_n),
      .baud_strobe  (baud),
      .tx_on        (tx_on),
      .sym_code     (sym),
      .rx_gain_code (gain),
      .loop_on      (loop_on),
      .boost_on     (boost_on),
      .ser_out      (ser_out),
      .word_active  (word_active)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_word(logic en, logic [1:0] s, logic [2:0] g, logic l, logic b);
      return {8'h00, b, l, g, (en ? s : 2'b00), en};
   endfunction

   // sample before a rising edge, then just after it
   task automatic step();
      @(negedge clk);
      #1.5;
      pre_act = word_active;
      pre_ser = ser_out;
      @(posedge clk);
      #0.5;
      // R9: nothing moves across the rising edge
      check(word_active === pre_act && ser_out === pre_ser, "R9",
            int'({word_active, ser_out}), int'({pre_act, pre_ser}), "output moved at rising edge");
   endtask

   task automatic run_frame(input logic en, input logic [1:0] s, input logic [2:0] g,
                            input logic l, input logic b, input bit disturb);
      logic [15:0] w;
      w = exp_word(en, s, g, l, b);
      tx_on = en; sym = s; gain = g; loop_on = l; boost_on = b;
      baud = 1'b1;
      for (int k = 1; k <= PER; k++) begin
         int  idx;
         bit  exp_act;
         bit  exp_bit;
         string tag;
         step();
         idx     = k - LAT;
         exp_act = (k >= LAT) && (k < LAT + WB);
         exp_bit = exp_act ? w[WB-1-idx] : 1'b0;
         if (k == LAT)        tag = "R2";
         else if (disturb)    tag = "R10";
         else                 tag = "R3";
         check(word_active === exp_act, tag, int'(word_active), int'(exp_act), "word_active");
         if (!exp_act)                           tag = "R8";
         else if (idx < 8)                       tag = "R5";
         else if (!en && (idx == 13 || idx == 14)) tag = "R6";
         else if (disturb)                       tag = "R7";
         else                                    tag = "R4";
         check(ser_out === exp_bit, tag, int'(ser_out), int'(exp_bit), "ser_out bit");
         if (disturb && k == 6) begin
            // R7: input changes after capture; R10: strobe re-edge mid word
            tx_on = ~en; sym = ~s; gain = ~g; loop_on = ~l; boost_on = ~b;
            baud = 1'b0;
         end
         if (disturb && k == 8) baud = 1'b1;
         if (k == 24) baud = 1'b0;
      end
   endtask

   initial begin
      int act_cnt;
      // R1: reset state
      step();
      check(word_active === 1'b0 && ser_out === 1'b0, "R1",
            int'({word_active, ser_out}), 0, "outputs in reset");
      step();
      rst_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         step();
         check(word_active === 1'b0 && ser_out === 1'b0, "R1",
               int'({word_active, ser_out}), 0, "outputs idle before first strobe");
      end

      // exhaustive field sweep
      for (int e = 0; e < 2; e++)
         for (int s = 0; s < 4; s++)
            for (int g = 0; g < 8; g++)
               for (int l = 0; l < 2; l++)
                  for (int b = 0; b < 2; b++)
                     run_frame(e[0], 2'(s), 3'(g), l[0], b[0], (g % 3) == 1);

      // R10: strobe held high gives exactly one frame
      tx_on = 1'b1; sym = 2'b11; gain = 3'b101; loop_on = 1'b1; boost_on = 1'b1;
      baud = 1'b1;
      act_cnt = 0;
      for (int k = 0; k < 3 * PER; k++) begin
         step();
         if (word_active === 1'b1) act_cnt++;
      end
      check(act_cnt == WB, "R10", act_cnt, WB, "active periods with strobe held high");
      baud = 1'b0;
      for (int k = 0; k < 4; k++) step();
      check(word_active === 1'b0, "R10", int'(word_active), 0, "no frame on falling strobe");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule